// File: doc/BRIEF.md
# Sticky Diagnostic Error-Flag Register

This block gathers error conditions from several parts of a sensor device into one 16-bit status word. Six conditions arrive as level inputs: two alarm levels, a flash checksum failure, a self-test failure, a sensor over-range and a flash update failure. The block latches them only when the sample-cycle strobe pulses. A seventh flag comes from a built-in monitor on the serial port. The monitor counts serial clock rising edges while chip-select is low. It raises an error when chip-select returns high and the count is not a whole multiple of the word length.

Flags are sticky. A read strobe clears the whole word. If a condition is still present at the next sample strobe, its flag sets again. When a new event and a read clear fall in the same clock cycle, the event takes priority, so no error is lost. All inputs are assumed to be synchronous to `clk`. Serial clock and chip-select levels must each be held for at least one `clk` cycle.

Top module: `diag_status_reg`

## Requirements
- R1: A synchronous active-high reset sets `stat_o` to 0x0000.
- R2: In the cycle after a clock edge at which `smp_stb` is 1, each source input that is 1 sets its flag. The bit positions are: `alm2_i`→9, `alm1_i`→8, `chksum_fail_i`→6, `selftest_fail_i`→5, `ovr_rng_i`→4, `flash_upd_fail_i`→2. Without `smp_stb`, the source inputs have no effect.
- R3: A set flag stays 1 after its source drops, until a read clear.
- R4: An edge with `rd_clr` = 1 and no new event makes every bit of `stat_o` 0 from the next cycle.
- R5: A source that is still 1 at the first sample strobe after a clear sets its flag again.
- R6: When `rd_clr` and an event occur at the same edge, the event's bit ends up 1 and all other bits end up 0.
- R7: Bit 3 sets one cycle after the edge at which `spi_cs_n` is first seen high again, when the number of `spi_sclk` rising edges counted while `spi_cs_n` was low is not a multiple of 16. Counts of 0, 16 and 32 leave bit 3 at 0.
- R8: Bits 15:10, 7 and 1:0 always read 0.
- R9: `spi_sclk` edges while `spi_cs_n` is high are not counted, and each transaction starts counting from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | Sample-cycle boundary pulse |
| rd_clr | input | 1 | Read strobe; clears the word |
| alm2_i | input | 1 | Alarm 2 level |
| alm1_i | input | 1 | Alarm 1 level |
| chksum_fail_i | input | 1 | Flash checksum failure level |
| selftest_fail_i | input | 1 | Self-test failure level |
| ovr_rng_i | input | 1 | Sensor over-range level |
| flash_upd_fail_i | input | 1 | Flash update failure level |
| spi_cs_n | input | 1 | Serial chip-select, active low |
| spi_sclk | input | 1 | Serial clock level, sampled by `clk` |
| stat_o | output | 16 | Registered status word |

## Verification
Every result is due exactly one `clk` edge after its cause:
- For a strobed flag, the cause is the edge that samples `smp_stb`.
- For a clear, it is the edge that samples `rd_clr`.
- For the frame-length flag, it is the edge that first sees `spi_cs_n` high.

The bench drives every input just after a rising edge and then steps one edge. It compares `stat_o` one time unit after that edge, which is the first point where the new value is visible.

Negative cases use the same timing. They check at the same point that a stimulus left the word unchanged, before any later stimulus could mask it.

// File: rtl/diag_pkg.sv
package diag_pkg;
  localparam int STAT_W  = 16;
  localparam int SPI_BIT = 3;
  localparam int SRC_N   = 6;
  // bit position of each strobed source, index order matches the source vector
  localparam int SRC_POS [SRC_N] = '{9, 8, 6, 5, 4, 2};
endpackage

// File: rtl/spi_frame_chk.sv
module spi_frame_chk #(
  parameter int WORD_BITS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sclk,
  output logic frame_err
);
  localparam int CNT_W = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BITS - 1);

  logic             cs_q, sclk_q;
  logic [CNT_W-1:0] cnt;
  logic             edge_in_frame, frame_end;

  assign edge_in_frame = sclk & ~sclk_q & ~cs_n;
  assign frame_end     = cs_n & ~cs_q;
  assign frame_err     = frame_end & (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
      cnt    <= '0;
    end else begin
      cs_q   <= cs_n;
      sclk_q <= sclk;
      if (cs_n)
        cnt <= '0;
      else if (edge_in_frame)
        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/diag_flag_reg.sv
module diag_flag_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] set_vec,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (clr ? '0 : q) | set_vec;
  end
endmodule

// File: rtl/diag_status_reg.sv
module diag_status_reg
  import diag_pkg::*;
#(
  parameter int WORD_BITS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_stb,
  input  logic              rd_clr,
  input  logic              alm2_i,
  input  logic              alm1_i,
  input  logic              chksum_fail_i,
  input  logic              selftest_fail_i,
  input  logic              ovr_rng_i,
  input  logic              flash_upd_fail_i,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  output logic [STAT_W-1:0] stat_o
);
  logic [SRC_N-1:0]  src;
  logic [STAT_W-1:0] set_vec;
  logic              frame_err;

  assign src = {alm2_i, alm1_i, chksum_fail_i, selftest_fail_i, ovr_rng_i, flash_upd_fail_i};

  spi_frame_chk #(.WORD_BITS(WORD_BITS)) u_spi (
    .clk(clk), .rst(rst), .cs_n(spi_cs_n), .sclk(spi_sclk), .frame_err(frame_err)
  );

  always_comb begin
    set_vec = '0;
    for (int i = 0; i < SRC_N; i++)
      set_vec[SRC_POS[i]] = smp_stb & src[SRC_N-1-i];
    set_vec[SPI_BIT] = frame_err;
  end

  diag_flag_reg #(.W(STAT_W)) u_flags (
    .clk(clk), .rst(rst), .clr(rd_clr), .set_vec(set_vec), .q(stat_o)
  );
endmodule

// File: rtl/diag_status_chk.sv
module diag_status_chk (
  input logic        clk,
  input logic        rst,
  input logic        smp_stb,
  input logic        rd_clr,
  input logic        alm1_i,
  input logic        ovr_rng_i,
  input logic        spi_cs_n,
  input logic [15:0] stat_o
);
  p_reset_zero_r1: assert property (@(posedge clk) rst |=> stat_o == 16'h0000);

  p_strobe_sets_r2: assert property (@(posedge clk) disable iff (rst)
    smp_stb && alm1_i |=> stat_o[8]);

  p_no_strobe_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !smp_stb && !rd_clr |=> (stat_o & 16'hFFF7) == ($past(stat_o) & 16'hFFF7));

  p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    !rd_clr |=> (stat_o & $past(stat_o)) == $past(stat_o));

  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    rd_clr && !smp_stb && !spi_cs_n |=> stat_o == 16'h0000);

  p_event_wins_r6: assert property (@(posedge clk) disable iff (rst)
    rd_clr && smp_stb && ovr_rng_i |=> stat_o[4]);

  p_frame_end_only_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_o[3]) |-> $past(spi_cs_n));
endmodule

bind diag_status_reg diag_status_chk u_chk (
  .clk(clk), .rst(rst), .smp_stb(smp_stb), .rd_clr(rd_clr), .alm1_i(alm1_i),
  .ovr_rng_i(ovr_rng_i), .spi_cs_n(spi_cs_n), .stat_o(stat_o)
);

// File: tb/diag_status_reg_tb.sv
module diag_status_reg_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_stb = 0, rd_clr = 0;
  logic alm2_i = 0, alm1_i = 0, chksum_fail_i = 0, selftest_fail_i = 0;
  logic ovr_rng_i = 0, flash_upd_fail_i = 0;
  logic spi_cs_n = 1, spi_sclk = 0;
  logic [15:0] stat_o;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2 clk = ~clk;

  diag_status_reg dut_i (.*);

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 50000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected fewer", cyc);
      summary();
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic do_clear();
    rd_clr = 1; step(); rd_clr = 0;
  endtask

  task automatic set_src(logic [5:0] v);
    {alm2_i, alm1_i, chksum_fail_i, selftest_fail_i, ovr_rng_i, flash_upd_fail_i} = v;
  endtask

  task automatic strobe();
    smp_stb = 1; step(); smp_stb = 0;
  endtask

  task automatic t_reset();
    check("R1 reset value", stat_o, 16'h0000);
  endtask

  task automatic t_sources();
    logic [15:0] pos [6] = '{16'h0200, 16'h0100, 16'h0040, 16'h0020, 16'h0010, 16'h0004};
    for (int i = 0; i < 6; i++) begin
      set_src(6'b100000 >> i);
      step();
      check("R2 no effect without strobe", stat_o, 16'h0000);
      strobe();
      check("R2 source sets its bit", stat_o, pos[i]);
      set_src(6'b0);
      step(); step();
      check("R3 flag sticky after source drops", stat_o, pos[i]);
      do_clear();
      check("R4 read clears word", stat_o, 16'h0000);
    end
  endtask

  task automatic t_persist();
    set_src(6'b000100);
    strobe();
    do_clear();
    check("R4 clear with source still high", stat_o, 16'h0000);
    step();
    check("R5 stays clear until strobe", stat_o, 16'h0000);
    strobe();
    check("R5 persistent source sets again", stat_o, 16'h0020);
    set_src(6'b0);
    do_clear();
  endtask

  task automatic t_collision();
    set_src(6'b010000);
    strobe();
    set_src(6'b000010);
    smp_stb = 1; rd_clr = 1; step(); smp_stb = 0; rd_clr = 0;
    check("R6 event wins over clear", stat_o, 16'h0010);
    set_src(6'b0);
    do_clear();
  endtask

  task automatic spi_frame(int n);
    spi_cs_n = 0; step();
    for (int k = 0; k < n; k++) begin
      spi_sclk = 1; step(); spi_sclk = 0; step();
    end
    spi_cs_n = 1; step();
  endtask

  task automatic t_spi();
    int good [3] = '{0, 16, 32};
    int bad  [3] = '{15, 17, 1};
    for (int i = 0; i < 3; i++) begin
      spi_frame(good[i]);
      check("R7 whole-word frame no error", stat_o, 16'h0000);
      step();
    end
    for (int i = 0; i < 3; i++) begin
      spi_frame(bad[i]);
      check("R7 partial frame sets bit 3", stat_o, 16'h0008);
      step();
      check("R7 bit 3 sticky", stat_o, 16'h0008);
      do_clear();
    end
    for (int k = 0; k < 5; k++) begin
      spi_sclk = 1; step(); spi_sclk = 0; step();
    end
    spi_frame(16);
    check("R9 idle edges not counted", stat_o, 16'h0000);
    spi_frame(3);
    do_clear();
    spi_frame(13);
    check("R9 count restarts each frame", stat_o, 16'h0008);
    do_clear();
  endtask

  task automatic t_unused();
    set_src(6'b111111);
    strobe();
    spi_frame(5);
    check("R8 all flags set, unused bits zero", stat_o, 16'h037C);
    set_src(6'b0);
    do_clear();
    check("R4 clear after all flags", stat_o, 16'h0000);
  endtask

  initial begin
    step(); step();
    rst = 0;
    step();
    t_reset();
    t_sources();
    t_persist();
    t_collision();
    t_spi();
    t_unused();
    summary();
  end
endmodule